// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

The block carries 18-bit data between an A side and a B side, in both directions, with no inversion. Each direction has one storage element. While that direction's pass control is high, the element is transparent and its output follows the input at once. While pass is low, the element becomes a rising-edge register, and a capture-enable gates its strobe. Each direction also has an active-low drive control. When that control is high, the direction's output is released.

The strobes are not used as clocks. The block runs on one fast system clock and finds a rising strobe edge by comparing the strobe's current level with the level it had one system cycle earlier. Each output appears as a data vector plus a drive flag. A pad ring or a bench can turn these into a tri-state pin or check the high-impedance condition.

Top module: `duplex_latreg_xcvr`

## Requirements
- R1: Data is 18 bits wide in each direction. A bit on an input appears unchanged at the same bit position of the opposite output (A to B, B to A), with no inversion.
- R2: The two directions are independent. Activity on one direction's data and controls never changes the other direction's output.
- R3: While a direction's drive control (`*_drive_n`) is 1, its drive flag is 0 and its data output reads all zeros, whatever the other controls are.
- R4: While `*_drive_n` is 0, the drive flag is 1 and the output shows the storage element's contents. This includes values captured while the output was released.
- R5: While `*_pass` is 1, the output equals the input in the same cycle, whatever the strobe and the capture-enable are doing.
- R6: While `*_pass` is 0 and `*_cap_en_n` is 1, a rising strobe edge does not change the stored value.
- R7: While `*_pass` is 0 and `*_cap_en_n` is 0, a rising strobe edge captures the input. A strobe edge counts as rising when the strobe is seen at 1 on a system clock edge after being 0 on the previous one. The captured value is visible after that system clock edge.
- R8: While `*_pass` is 0 and the strobe stays low or stays high, the stored value does not change. When `*_pass` falls, the element keeps the last value that passed through.
- R9: After reset, both storage elements hold zero. A strobe that is already high when reset is released does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_in | input | 18 | Data received on the A side |
| a_out | output | 18 | Data sent toward the A side (B-to-A path) |
| a_drv | output | 1 | A-side drive flag, 0 means high impedance |
| b_in | input | 18 | Data received on the B side |
| b_out | output | 18 | Data sent toward the B side (A-to-B path) |
| b_drv | output | 1 | B-side drive flag, 0 means high impedance |
| ab_drive_n | input | 1 | A-to-B output release, active high |
| ab_pass | input | 1 | A-to-B transparent select |
| ab_cap_en_n | input | 1 | A-to-B capture enable, active low |
| ab_strobe | input | 1 | A-to-B capture strobe |
| ba_drive_n | input | 1 | B-to-A output release, active high |
| ba_pass | input | 1 | B-to-A transparent select |
| ba_cap_en_n | input | 1 | B-to-A capture enable, active low |
| ba_strobe | input | 1 | B-to-A capture strobe |

## Verification
The release state, the drive flag and the transparent path are combinational, so they are valid in the same cycle as the control change. A strobe capture, and a value loaded while transparent that is later held, both take effect on the first system clock rising edge that sees the new inputs. The bench changes inputs only on the falling clock edge and checks every expectation 2 ns after the following rising edge. By then the registered results have settled, and the inputs have not yet moved again. Each step checks both directions, so the idle direction is tested for independence at the same moment the active one is tested.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int unsigned XCVR_W_DEFAULT = 18;
  localparam int unsigned XCVR_LANES     = 2;

  // Per-direction controls
  typedef struct packed {
    logic drive_n;   // 1 releases the output
    logic pass;      // 1 makes the element transparent
    logic cap_en_n;  // 0 allows a strobe edge to capture
    logic strobe;    // capture strobe, sampled by the system clock
  } lane_ctl_t;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s_n = chain_q[STAGES-1];

endmodule

// File: rtl/xcvr_rise.sv
module xcvr_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);

  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d = lvl;
    rise  = lvl & ~lvl_q;
  end

  // Reset the previous level to 1 so that a strobe already high is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl_d;
  end

  // R7: a rise needs the strobe to go low again before the next one
  a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/xcvr_hold.sv
module xcvr_hold #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         pass,
  input  logic         cap_en_n,
  input  logic         rise,
  output logic [W-1:0] held
);

  logic [W-1:0] held_q;
  logic [W-1:0] held_d;
  logic         load;

  always_comb begin
    load   = 1'b0;
    held_d = held_q;
    if (pass) begin
      load = 1'b1;
    end else if (rise && !cap_en_n) begin
      load = 1'b1;
    end
    if (load) held_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_q <= '0;
    else if (load) held_q <= held_d;
  end

  assign held = held_q;

  // R6: capture disabled keeps the stored value
  a_r6_blocked_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && cap_en_n) |=> $stable(held_q));

  // R7: an enabled rising edge stores the input seen at that edge
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && !cap_en_n && rise) |=> (held_q == $past(din)));

  // R8: no edge and not transparent means no change
  a_r8_steady_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && !rise) |=> $stable(held_q));

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  lane_ctl_t    ctl,
  output logic [W-1:0] q,
  output logic         drv
);

  logic         rise;
  logic [W-1:0] held;
  logic [W-1:0] view;

  xcvr_rise u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (ctl.strobe),
    .rise (rise)
  );

  xcvr_hold #(.W(W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .pass    (ctl.pass),
    .cap_en_n(ctl.cap_en_n),
    .rise    (rise),
    .held    (held)
  );

  always_comb begin
    view = ctl.pass ? din : held;
    drv  = ~ctl.drive_n;
    q    = drv ? view : '0;
  end

endmodule

// File: rtl/duplex_latreg_xcvr.sv
module duplex_latreg_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  input  logic         ab_drive_n,
  input  logic         ab_pass,
  input  logic         ab_cap_en_n,
  input  logic         ab_strobe,
  input  logic         ba_drive_n,
  input  logic         ba_pass,
  input  logic         ba_cap_en_n,
  input  logic         ba_strobe
);

  localparam int unsigned NL = XCVR_LANES;

  logic         rst_s_n;
  lane_ctl_t    ctl [NL];
  logic [W-1:0] src [NL];
  logic [W-1:0] dst [NL];
  logic         drv [NL];

  xcvr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_s_n(rst_s_n)
  );

  // Lane 0 carries A to B, lane 1 carries B to A
  always_comb begin
    ctl[0] = '{drive_n: ab_drive_n, pass: ab_pass, cap_en_n: ab_cap_en_n, strobe: ab_strobe};
    ctl[1] = '{drive_n: ba_drive_n, pass: ba_pass, cap_en_n: ba_cap_en_n, strobe: ba_strobe};
    src[0] = a_in;
    src[1] = b_in;
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    xcvr_lane #(.W(W)) u_lane (
      .clk  (clk),
      .rst_n(rst_s_n),
      .din  (src[g]),
      .ctl  (ctl[g]),
      .q    (dst[g]),
      .drv  (drv[g])
    );
  end

  assign b_out = dst[0];
  assign b_drv = drv[0];
  assign a_out = dst[1];
  assign a_drv = drv[1];

  // R3: released output neither drives nor shows data
  a_r3_release_ab: assert property (@(posedge clk) disable iff (!rst_s_n)
    ab_drive_n |-> (!b_drv && b_out == '0));
  a_r3_release_ba: assert property (@(posedge clk) disable iff (!rst_s_n)
    ba_drive_n |-> (!a_drv && a_out == '0));

  // R5: transparent and driven means the opposite port mirrors the input
  a_r5_follow_ab: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ab_drive_n && ab_pass) |-> (b_out == a_in));
  a_r5_follow_ba: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ba_drive_n && ba_pass) |-> (a_out == b_in));

endmodule

// File: tb/sim_duplex_latreg_xcvr.sv
module sim_duplex_latreg_xcvr;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] din [2];
  logic         dn [2];
  logic         ps [2];
  logic         ce [2];
  logic         st [2];
  logic [W-1:0] a_out, b_out;
  logic         a_drv, b_drv;

  always #4 clk = ~clk;

  duplex_latreg_xcvr #(.W(W)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_in       (din[0]),
    .a_out      (a_out),
    .a_drv      (a_drv),
    .b_in       (din[1]),
    .b_out      (b_out),
    .b_drv      (b_drv),
    .ab_drive_n (dn[0]),
    .ab_pass    (ps[0]),
    .ab_cap_en_n(ce[0]),
    .ab_strobe  (st[0]),
    .ba_drive_n (dn[1]),
    .ba_pass    (ps[1]),
    .ba_cap_en_n(ce[1]),
    .ba_strobe  (st[1])
  );

  typedef struct packed {
    logic         dir;
    logic         drv;
    logic [W-1:0] data;
  } exp_t;

  exp_t         exp_q [$];
  string        tag_q [$];
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;
  logic         idle_drv;
  logic [W-1:0] idle_data;
  string        idle_tag;

  function automatic logic [W-1:0] got_data(input logic d);
    return d ? a_out : b_out;
  endfunction

  function automatic logic got_drv(input logic d);
    return d ? a_drv : b_drv;
  endfunction

  // Monitor: pops every expectation due at this rising edge
  always @(posedge clk) begin
    #2;
    while (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (got_drv(e.dir) !== e.drv || got_data(e.dir) !== e.data) begin
        n_fail++;
        $display("FAIL %s dir%0d: actual drv=%0b data=%h, expected drv=%0b data=%h",
                 t, e.dir, got_drv(e.dir), got_data(e.dir), e.drv, e.data);
      end
    end
  end

  // Driver: apply at the falling edge, queue results due after the next rising edge
  task automatic step(input int d, input logic dn_v, input logic ps_v, input logic ce_v,
                      input logic st_v, input logic [W-1:0] din_v,
                      input logic e_drv, input logic [W-1:0] e_data, input string tag);
    logic dsel;
    dsel = d[0];
    dn[d] = dn_v; ps[d] = ps_v; ce[d] = ce_v; st[d] = st_v; din[d] = din_v;
    @(posedge clk);
    exp_q.push_back('{dir: dsel, drv: e_drv, data: e_data});
    tag_q.push_back(tag);
    exp_q.push_back('{dir: ~dsel, drv: idle_drv, data: idle_data});
    tag_q.push_back(idle_tag);
    @(negedge clk);
  endtask

  task automatic run_dir(input int d, input logic [W-1:0] k);
    logic [W-1:0] v1, v2, v3, v4, v5, v6, v7;
    v1 = 18'h20001 ^ k; v2 = 18'h15555 ^ k; v3 = 18'h0AAAA ^ k; v4 = 18'h3FFFF ^ k;
    v5 = 18'h1E0F0 ^ k; v6 = 18'h00FFF ^ k; v7 = 18'h3F000 ^ k;
    step(d, 0, 1, 1, 0, v1, 1, v1, "R5 transparent follow");
    step(d, 0, 1, 1, 1, v2, 1, v2, "R5 strobe ignored while transparent");
    step(d, 0, 1, 0, 0, v3, 1, v3, "R1 non-inverting full width");
    step(d, 0, 0, 1, 0, v4, 1, v3, "R8 last passed value kept on pass drop");
    step(d, 0, 0, 1, 1, v4, 1, v3, "R6 edge blocked by capture disable");
    step(d, 0, 0, 1, 0, v5, 1, v3, "R8 strobe low holds");
    step(d, 0, 0, 0, 0, v5, 1, v3, "R8 enabled without edge holds");
    step(d, 0, 0, 0, 1, v5, 1, v5, "R7 capture on rising strobe");
    step(d, 0, 0, 0, 1, v6, 1, v5, "R8 strobe held high holds");
    step(d, 1, 0, 0, 1, v6, 0, '0, "R3 released output");
    step(d, 1, 1, 0, 1, v6, 0, '0, "R3 released while transparent");
    step(d, 1, 0, 0, 0, v7, 0, '0, "R3 released strobe low");
    step(d, 1, 0, 0, 1, v7, 0, '0, "R3 released during capture");
    step(d, 0, 0, 0, 1, v1, 1, v7, "R4 drive shows value captured while released");
  endtask

  initial begin
    rst_n = 1'b0;
    dn[0] = 0; ps[0] = 0; ce[0] = 1; st[0] = 0; din[0] = '0;
    // R9: B-to-A strobe high and capture enabled through reset release
    dn[1] = 0; ps[1] = 0; ce[1] = 0; st[1] = 1; din[1] = 18'h12345;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_drv = 1'b1; idle_data = '0; idle_tag = "R9 no false edge after reset";
    step(0, 0, 0, 1, 0, '0, 1, '0, "R9 storage zero after reset");
    idle_tag = "R2 other direction untouched";
    run_dir(0, '0);
    idle_drv = 1'b1; idle_data = 18'h3F000;
    run_dir(1, 18'h2D2D2);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual run unfinished, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule